// File: doc/BRIEF.md
# Picture Tube Protection Controller

This block watches the safety conditions of a display drive and sets two outputs: a blanking request for the RGB drive stages and an enable for the horizontal drive. It has three protection paths, and the RGB blank request is the OR of their results.

The first path supervises vertical flyback. Every field must contain a falling edge on the flyback input. A field that closes at the field-start strobe without one blanks the picture. The second path handles a safety input that an external comparator pair splits into three zones. The two comparator outputs are cleaned digitally with a short sample-majority filter. The middle zone blanks RGB. The top zone also cuts the horizontal drive, and that cut holds until software clears it. The third path blanks the drive for the whole flyback interval when software enables that option.

All inputs are taken to be already synchronous to `clk_i`.

Top module: `tube_protect`

## Requirements
- R1: While reset is asserted, `rgb_blank_o` is 1 and `hdrv_en_o` is 1.
- R2: Each comparator input is filtered over its last 4 samples. The filtered level goes to 1 when at least 3 of the 4 samples are 1, goes to 0 when at most 1 is 1, and otherwise holds. A high pulse of 1 or 2 cycles does not change it.
- R3: With both filtered comparators at 0 (normal zone), the safety path adds no blanking and leaves `hdrv_en_o` unchanged.
- R4: With the filtered lower comparator `cmp_lo_i` at 1 and the upper one `cmp_hi_i` at 0 (middle zone), RGB is blanked and `hdrv_en_o` stays 1.
- R5: With the filtered upper comparator at 1 (top zone, whatever the lower one reads), RGB is blanked and `hdrv_en_o` drops to 0.
- R6: Once `hdrv_en_o` is 0, it returns to 1 only on a cycle where `hdrv_clear_i` is 1 and the filtered upper comparator is 0. A clear while the upper comparator reads 1 is ignored.
- R7: A `field_start_i` pulse with no falling edge of `flyback_i` since the previous pulse (a same-cycle edge counts) sets the missing-flyback blank. A later pulse that closes a field containing such an edge clears it.
- R8: When `fb_shutoff_en_i` is 1, RGB is blanked while `flyback_i` is 1. When it is 0, the level of `flyback_i` has no effect on blanking.
- R9: `rgb_blank_o` is a register. It equals, one cycle later, the OR of the missing-flyback state, the safety blank and the enabled flyback blank.
- R10: After reset, RGB stays blanked until a field containing a flyback falling edge has been closed by `field_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flyback_i | input | 1 | Vertical flyback level, 1 during flyback |
| field_start_i | input | 1 | One-cycle strobe at each field start |
| cmp_lo_i | input | 1 | Lower safety comparator output |
| cmp_hi_i | input | 1 | Upper safety comparator output |
| fb_shutoff_en_i | input | 1 | Software enable for blanking during flyback |
| hdrv_clear_i | input | 1 | Software clear of the latched horizontal drive cut |
| rgb_blank_o | output | 1 | RGB blank request |
| hdrv_en_o | output | 1 | Horizontal drive enable |

## Verification
The assertions take all inputs to be synchronous to the clock. They do not require the comparator pair to be ordered: the upper output may read 1 while the lower one reads 0, and that case counts as the top zone. The bench changes every input on the falling clock edge. It holds comparator levels long enough for the 4-sample filter to settle, except in the deliberate short-pulse cases. Comparator settings, enable and flyback level are swept exhaustively, and each setting is preceded by a proper field so that missing-flyback blanking does not mask the result.

// File: rtl/tube_protect_pkg.sv
package tube_protect_pkg;
  typedef enum logic [1:0] {
    ZONE_NORMAL = 2'd0,
    ZONE_MID    = 2'd1,
    ZONE_HIGH   = 2'd2
  } zone_e;
endpackage

// File: rtl/tp_majority_filter.sv
module tp_majority_filter #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned HI_CNT = 3,
  parameter int unsigned LO_CNT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;
  logic [CW-1:0]    ones;

  assign hist_d = {hist_q[DEPTH-2:0], raw_i};

  always_comb begin
    ones = '0;
    for (int i = 0; i < DEPTH; i++) ones = ones + CW'(hist_d[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_o <= 1'b0;
    end else begin
      hist_q <= hist_d;
      if (ones >= CW'(HI_CNT))      filt_o <= 1'b1;
      else if (ones <= CW'(LO_CNT)) filt_o <= 1'b0;
    end
  end

  a_r2_rise_needs_majority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_o) |-> ($countones(hist_q) >= HI_CNT));
  a_r2_fall_needs_minority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_o) |-> ($countones(hist_q) <= LO_CNT));
endmodule

// File: rtl/tp_flyback_watch.sv
module tp_flyback_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flyback_i,
  input  logic field_start_i,
  output logic missing_o
);
  logic fb_q;
  logic seen_q;
  logic fall;

  assign fall = fb_q & ~flyback_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q      <= 1'b0;
      seen_q    <= 1'b0;
      missing_o <= 1'b1;
    end else begin
      fb_q <= flyback_i;
      if (field_start_i) begin
        missing_o <= ~(seen_q | fall);
        seen_q    <= 1'b0;
      end else if (fall) begin
        seen_q <= 1'b1;
      end
    end
  end

  a_r7_no_edge_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && !seen_q && !fall) |=> missing_o);
  a_r7_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && (seen_q || fall)) |=> !missing_o);
  a_r10_hold_between_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(missing_o));
endmodule

// File: rtl/tp_safety_zone.sv
module tp_safety_zone
  import tube_protect_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_i,
  input  logic hi_i,
  input  logic clear_i,
  output logic blank_o,
  output logic hdrv_en_o
);
  zone_e zone;
  logic  cut_q;

  always_comb begin
    if (hi_i)      zone = ZONE_HIGH;
    else if (lo_i) zone = ZONE_MID;
    else           zone = ZONE_NORMAL;
  end

  assign blank_o   = (zone != ZONE_NORMAL);
  assign hdrv_en_o = ~cut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cut_q <= 1'b0;
    else if (zone == ZONE_HIGH)              cut_q <= 1'b1;
    else if (clear_i)                        cut_q <= 1'b0;
  end

  a_r5_high_cuts_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_i |=> !hdrv_en_o);
  a_r6_restore_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdrv_en_o) |-> ($past(clear_i) && !$past(hi_i)));
  a_r4_mid_keeps_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_i && !hi_i && hdrv_en_o) |=> hdrv_en_o);
endmodule

// File: rtl/tube_protect.sv
module tube_protect #(
  parameter int unsigned FILT_DEPTH = 4,
  parameter int unsigned FILT_HI    = 3,
  parameter int unsigned FILT_LO    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flyback_i,
  input  logic field_start_i,
  input  logic cmp_lo_i,
  input  logic cmp_hi_i,
  input  logic fb_shutoff_en_i,
  input  logic hdrv_clear_i,
  output logic rgb_blank_o,
  output logic hdrv_en_o
);
  localparam int unsigned NCMP = 2;

  logic [NCMP-1:0] cmp_raw;
  logic [NCMP-1:0] cmp_filt;
  logic            missing;
  logic            safety_blank;
  logic            fb_blank;
  logic            blank_d;

  assign cmp_raw = {cmp_hi_i, cmp_lo_i};

  for (genvar g = 0; g < NCMP; g++) begin : g_filt
    tp_majority_filter #(
      .DEPTH (FILT_DEPTH),
      .HI_CNT(FILT_HI),
      .LO_CNT(FILT_LO)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (cmp_raw[g]),
      .filt_o(cmp_filt[g])
    );
  end

  tp_flyback_watch u_fbw (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flyback_i    (flyback_i),
    .field_start_i(field_start_i),
    .missing_o    (missing)
  );

  tp_safety_zone u_zone (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_i     (cmp_filt[0]),
    .hi_i     (cmp_filt[1]),
    .clear_i  (hdrv_clear_i),
    .blank_o  (safety_blank),
    .hdrv_en_o(hdrv_en_o)
  );

  assign fb_blank = fb_shutoff_en_i & flyback_i;
  assign blank_d  = missing | safety_blank | fb_blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_blank_o <= 1'b1;
    else         rgb_blank_o <= blank_d;
  end

  a_r8_flyback_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_shutoff_en_i && flyback_i) |=> rgb_blank_o);
  a_r9_missing_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missing |=> rgb_blank_o);
  a_r9_clear_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!missing && !safety_blank && !(fb_shutoff_en_i && flyback_i)) |=> !rgb_blank_o);
  a_r3_normal_zone_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_filt == '0) |-> !safety_blank);
endmodule

// File: tb/tb_tube_protect.sv
`timescale 1ns/1ps
module tb_tube_protect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flyback = 1'b0, field_start = 1'b0, lo = 1'b0, hi = 1'b0, en = 1'b0, clr = 1'b0;
  logic rgb_blank, hdrv_en;
  int   n_chk = 0, n_bad = 0;
  logic exp_cut = 1'b0;

  always #2.5 clk = ~clk;

  tube_protect dut (
    .clk_i(clk), .rst_ni(rst_n), .flyback_i(flyback), .field_start_i(field_start),
    .cmp_lo_i(lo), .cmp_hi_i(hi), .fb_shutoff_en_i(en), .hdrv_clear_i(clr),
    .rgb_blank_o(rgb_blank), .hdrv_en_o(hdrv_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic good_field();
    flyback = 1'b1; cyc(2);
    flyback = 1'b0; cyc(1);
    field_start = 1'b1; cyc(1);
    field_start = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(2);
    chk("R1 blank in reset", rgb_blank, 1'b1);
    chk("R1 hdrv in reset", hdrv_en, 1'b1);
    rst_n = 1'b1;
    cyc(3);
    chk("R10 blank before first field", rgb_blank, 1'b1);
    field_start = 1'b1; cyc(1); field_start = 1'b0; cyc(2);
    chk("R10 edgeless first field", rgb_blank, 1'b1);
    good_field();
    chk("R10 cleared after valid field", rgb_blank, 1'b0);

    field_start = 1'b1; cyc(1); field_start = 1'b0; cyc(2);
    chk("R7 missing edge blanks", rgb_blank, 1'b1);
    cyc(5);
    chk("R7 stays blanked", rgb_blank, 1'b1);
    good_field();
    chk("R7 recovers", rgb_blank, 1'b0);
    // edge in the same cycle as the strobe
    flyback = 1'b1; cyc(2);
    flyback = 1'b0; field_start = 1'b1; cyc(1); field_start = 1'b0; cyc(2);
    chk("R7 same-cycle edge counts", rgb_blank, 1'b0);

    // R2 filter pulses
    lo = 1'b1; cyc(1); lo = 1'b0; cyc(6);
    chk("R2 one-cycle glitch", rgb_blank, 1'b0);
    lo = 1'b1; cyc(2); lo = 1'b0; cyc(6);
    chk("R2 two-cycle pulse", rgb_blank, 1'b0);
    lo = 1'b1; cyc(3); lo = 1'b0; cyc(2);
    chk("R2 three-cycle pulse passes", rgb_blank, 1'b1);
    cyc(4);
    chk("R2 filter releases", rgb_blank, 1'b0);

    // R9 latency
    en = 1'b1; flyback = 1'b1; #1;
    chk("R9 no same-cycle change", rgb_blank, 1'b0);
    cyc(1);
    chk("R9 one-cycle latency", rgb_blank, 1'b1);
    flyback = 1'b0; en = 1'b0; cyc(1);
    field_start = 1'b1; cyc(1); field_start = 1'b0; cyc(2);
    chk("R7 field with edge after R9", rgb_blank, 1'b0);

    // sweep: zones x enable x flyback level
    for (int z = 0; z < 4; z++) begin
      for (int e = 0; e < 2; e++) begin
        for (int f = 0; f < 2; f++) begin
          good_field();
          lo = z[0]; hi = z[1]; cyc(6);
          if (hi) exp_cut = 1'b1;
          en = e[0]; flyback = f[0]; cyc(2);
          chk(hi ? "R5 zone blank" : (lo ? "R4 zone blank" : "R3/R8 blank"),
              rgb_blank, lo | hi | (e[0] & f[0]));
          chk(hi ? "R5 drive cut" : "R4 drive kept", hdrv_en, ~exp_cut);
          if (hi) begin
            clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
            chk("R6 clear ignored while high", hdrv_en, 1'b0);
          end
          en = 1'b0; flyback = 1'b0; lo = 1'b0; hi = 1'b0; cyc(6);
          chk("R6 cut latched after drop", hdrv_en, ~exp_cut);
          clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
          exp_cut = 1'b0;
          chk("R6 clear restores", hdrv_en, 1'b1);
        end
      end
    end

    // R8 flyback ignored when disabled, sampled mid-flyback
    good_field();
    en = 1'b0; flyback = 1'b1; cyc(3);
    chk("R8 disabled flyback no effect", rgb_blank, 1'b0);
    flyback = 1'b0; cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule